// File: doc/BRIEF.md
# Message-Signalled Interrupt Write Generator

This block signals device interrupt events by writing one DWORD to a host address instead of driving an interrupt pin. Software programs a 64-bit target address, a 16-bit data value, an enable bit and a field that sets how many low data bits carry the event's vector number. Each interrupt request names a vector. The request becomes a single write on a valid/ready master port that feeds the device's posted-write path.

The block releases a message only after the status-block write for that event has been issued on the same ordered path. The host therefore sees the updated status before the interrupt and needs no flushing read. Requests are kept per vector, so repeated requests for one vector that has not yet been sent merge into one write. When several vectors are waiting, the lowest index goes first. The 32-bit payload carries zeros in its upper half. The master port also tells the path whether the target needs a 64-bit address cycle.

Top module: `msgint_writer`

## Requirements
- R1: After reset the address, data and control registers read zero, `m_valid` is low and every request pending before reset is dropped. A dropped request produces no write after enabling.
- R2: Register map on `cfg_addr`. 0x58 is control: bit 0 enables generation, bits 5:4 hold the vector-field width (0 to 3), and all other bits read zero. 0x5C holds address bits 31:0. 0x60 holds address bits 63:32. 0x64 holds the message data in bits 15:0, and bits 31:16 read zero. Writes occur when `cfg_we` is high at a clock edge, and `cfg_rdata` reflects the addressed register combinationally.
- R3: The payload has bits 31:16 equal to zero. Bits 15:0 equal the programmed data, except that the low N bits (N = vector-field width) are replaced by the low N bits of the vector.
- R4: `m_addr` equals {0x60 register, 0x5C register}. `m_addr64` is 1 exactly when the high address register is nonzero.
- R5: A request is not written until `sblk_issued` has pulsed in the cycle of the request or later. When the request or the pulse arrives with the block idle and enabled, `m_valid` rises one cycle after the later of the two.
- R6: While enable is clear no new write starts and requests stay pending. Setting enable releases them.
- R7: Once `m_valid` is high it stays high, with `m_addr`, `m_addr64` and `m_data` unchanged, until `m_ready` is sampled high. Register writes in that time do not alter the payload.
- R8: A request arriving while a write is outstanding is sent after that write's handshake. Among eligible vectors the lowest index is sent first.
- R9: Several requests for the same vector before its write starts produce exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| irq_req | input | 1 | Interrupt event request |
| irq_vec | input | 3 | Vector number of the request |
| sblk_issued | input | 1 | Status-block write has entered the posted path |
| m_valid | output | 1 | Message write request valid |
| m_ready | input | 1 | Path accepts the message write |
| m_addr | output | 64 | Message target address |
| m_addr64 | output | 1 | Target needs a 64-bit address cycle |
| m_data | output | 32 | Message DWORD payload |

## Verification
The payload is tried with vector-field widths 0, 2 and 3, using data and vector values whose low bits differ. This separates a correct bit mask from one that is off by one and from one that drops the vector. Addresses with a zero and a nonzero high half separate the 32-bit and 64-bit cycle selection. Three ordering patterns are run: a request before its status pulse, a request with the enable clear, and a reset with a request still pending. Each shows whether the block waits, holds or drops the request. A burst of out-of-order and repeated requests behind a stalled write checks queuing, lowest-index priority and merging.

// File: rtl/msgint_pkg.sv
package msgint_pkg;

   localparam int unsigned CFG_AW = 8;
   localparam int unsigned MM_W   = 2;
   localparam int unsigned VFLD_W = 3;

   localparam logic [CFG_AW-1:0] OFS_CTRL = 8'h58;
   localparam logic [CFG_AW-1:0] OFS_ALO  = 8'h5C;
   localparam logic [CFG_AW-1:0] OFS_AHI  = 8'h60;
   localparam logic [CFG_AW-1:0] OFS_DATA = 8'h64;

   // Merge the vector number into the low mm bits of the programmed data.
   function automatic logic [15:0] fold_vector(input logic [15:0] base,
                                               input logic [MM_W-1:0] mm,
                                               input logic [VFLD_W-1:0] vec);
      logic [15:0] mask;
      mask = 16'((17'd1 << mm) - 17'd1);
      return (base & ~mask) | ({13'd0, vec} & mask);
   endfunction

endpackage

// File: rtl/msgint_regs.sv
module msgint_regs
   import msgint_pkg::*;
#(
   parameter bit HI_ADDR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              enable,
   output logic [MM_W-1:0]   mm,
   output logic [31:0]       addr_lo,
   output logic [31:0]       addr_hi,
   output logic [15:0]       data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable  <= 1'b0;
         mm      <= '0;
         addr_lo <= '0;
         data    <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            OFS_CTRL: begin
               enable <= cfg_wdata[0];
               mm     <= cfg_wdata[5:4];
            end
            OFS_ALO:  addr_lo <= cfg_wdata;
            OFS_DATA: data    <= cfg_wdata[15:0];
            default: ;
         endcase
      end
   end

   generate
      if (HI_ADDR_EN) begin : g_hi
         logic [31:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               hi_q <= '0;
            else if (cfg_we && cfg_addr == OFS_AHI)
               hi_q <= cfg_wdata;
         end
         assign addr_hi = hi_q;
      end else begin : g_no_hi
         // 32-bit-only host: the high half is fixed at zero.
         assign addr_hi = '0;
      end
   endgenerate

   always_comb begin
      case (cfg_addr)
         OFS_CTRL: cfg_rdata = {26'd0, mm, 3'd0, enable};
         OFS_ALO:  cfg_rdata = addr_lo;
         OFS_AHI:  cfg_rdata = addr_hi;
         OFS_DATA: cfg_rdata = {16'd0, data};
         default:  cfg_rdata = '0;
      endcase
   end

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == OFS_CTRL) |=> (enable == $past(cfg_wdata[0])));

endmodule

// File: rtl/msgint_pend.sv
module msgint_pend #(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [VEC_W-1:0]   req_vec,
   input  logic               sblk,
   input  logic               take,
   input  logic [VEC_W-1:0]   take_vec,
   output logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] elig
);

   generate
      for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
         logic set_i, clr_i;
         assign set_i = req  && (req_vec  == VEC_W'(i));
         assign clr_i = take && (take_vec == VEC_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend[i] <= 1'b0;
               elig[i] <= 1'b0;
            end else if (clr_i) begin
               pend[i] <= set_i;
               elig[i] <= set_i && sblk;
            end else begin
               pend[i] <= pend[i] | set_i;
               elig[i] <= elig[i] | (sblk && (pend[i] | set_i));
            end
         end
      end
   endgenerate

   // R5: a vector may only become eligible through a status-block pulse.
   assert_elig_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (elig & ~pend) == '0);
   assert_elig_needs_sblk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sblk && !take) |=> (elig == $past(elig)));

endmodule

// File: rtl/msgint_launch.sv
module msgint_launch
   import msgint_pkg::*;
#(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [NUM_VEC-1:0] elig,
   input  logic [MM_W-1:0]    mm,
   input  logic [31:0]        addr_lo,
   input  logic [31:0]        addr_hi,
   input  logic [15:0]        data,
   input  logic               m_ready,
   output logic               take,
   output logic [VEC_W-1:0]   take_vec,
   output logic               m_valid,
   output logic [63:0]        m_addr,
   output logic               m_addr64,
   output logic [31:0]        m_data
);

   logic               found;
   logic [NUM_VEC-1:0] grant;

   // Lowest-index-first selection.
   always_comb begin
      found    = 1'b0;
      take_vec = '0;
      grant    = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (elig[i] && !found) begin
            found    = 1'b1;
            take_vec = VEC_W'(i);
            grant[i] = 1'b1;
         end
      end
   end

   assign take = enable && !m_valid && found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid  <= 1'b0;
         m_addr   <= '0;
         m_addr64 <= 1'b0;
         m_data   <= '0;
      end else if (take) begin
         m_valid  <= 1'b1;
         m_addr   <= {addr_hi, addr_lo};
         m_addr64 <= |addr_hi;
         m_data   <= {16'd0, fold_vector(data, mm, VFLD_W'(take_vec))};
      end else if (m_valid && m_ready) begin
         m_valid  <= 1'b0;
      end
   end

   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data)
                                 && $stable(m_addr64)));
   assert_launch_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_valid) |-> $past(enable));
   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_data[31:16] == 16'd0));

endmodule

// File: rtl/msgint_writer.sv
module msgint_writer
   import msgint_pkg::*;
#(
   parameter int unsigned NUM_VEC    = 8,
   parameter bit          HI_ADDR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              irq_req,
   input  logic [2:0]        irq_vec,
   input  logic              sblk_issued,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [63:0]       m_addr,
   output logic              m_addr64,
   output logic [31:0]       m_data
);

   localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

   initial begin
      if (NUM_VEC < 1 || NUM_VEC > (1 << VFLD_W))
         $error("NUM_VEC must lie between 1 and %0d", 1 << VFLD_W);
   end

   logic               enable;
   logic [MM_W-1:0]    mm;
   logic [31:0]        addr_lo, addr_hi;
   logic [15:0]        data;
   logic [NUM_VEC-1:0] pend, elig;
   logic               take;
   logic [VEC_W-1:0]   take_vec;
   logic               req_ok;

   // Requests naming a vector beyond NUM_VEC are discarded.
   assign req_ok = irq_req && (32'(irq_vec) < NUM_VEC);

   msgint_regs #(.HI_ADDR_EN(HI_ADDR_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .enable(enable), .mm(mm),
      .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data)
   );

   msgint_pend #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .req(req_ok), .req_vec(VEC_W'(irq_vec)),
      .sblk(sblk_issued), .take(take), .take_vec(take_vec),
      .pend(pend), .elig(elig)
   );

   msgint_launch #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_launch (
      .clk(clk), .rst_n(rst_n), .enable(enable), .elig(elig), .mm(mm),
      .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data), .m_ready(m_ready),
      .take(take), .take_vec(take_vec), .m_valid(m_valid), .m_addr(m_addr),
      .m_addr64(m_addr64), .m_data(m_data)
   );

   assert_take_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (pend != '0));

endmodule

// File: tb/msgint_writer_bench.sv
module msgint_writer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq_req = 1'b0;
   logic [2:0]  irq_vec = '0;
   logic        sblk_issued = 1'b0;
   logic        m_valid, m_addr64, m_ready = 1'b0;
   logic [63:0] m_addr;
   logic [31:0] m_data;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   msgint_writer u_msgint_writer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
      .irq_vec(irq_vec), .sblk_issued(sblk_issued), .m_valid(m_valid),
      .m_ready(m_ready), .m_addr(m_addr), .m_addr64(m_addr64), .m_data(m_data)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_payload(input logic [15:0] d, input int mm, input int v);
      logic [15:0] m;
      m = 16'((1 << mm) - 1);
      return {16'd0, (d & ~m) | (16'(v) & m)};
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      cyc(1);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      cfg_addr = a;
      #1;
      check(req, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic request(input int v, input logic sb);
      irq_req = 1'b1; irq_vec = 3'(v); sblk_issued = sb;
      cyc(1);
      irq_req = 1'b0; sblk_issued = 1'b0;
   endtask

   task automatic accept;
      m_ready = 1'b1;
      cyc(1);
      m_ready = 1'b0;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      check("R1 valid after reset", 64'(m_valid), 64'd0);
      rd("R1 ctrl reset", 8'h58, 32'h0);
      rd("R1 addr lo reset", 8'h5C, 32'h0);
      rd("R1 addr hi reset", 8'h60, 32'h0);
      rd("R1 data reset", 8'h64, 32'h0);
   endtask

   task automatic t_regs;
      wr(8'h5C, 32'hFEE0_1000);
      wr(8'h60, 32'h0000_0000);
      wr(8'h64, 32'hFFFF_4321);
      wr(8'h58, 32'hFFFF_FFFE);
      rd("R2 addr lo", 8'h5C, 32'hFEE0_1000);
      rd("R2 data upper zero", 8'h64, 32'h0000_4321);
      rd("R2 ctrl fields", 8'h58, 32'h0000_0030);
      wr(8'h60, 32'h1234_5678);
      rd("R2 addr hi", 8'h60, 32'h1234_5678);
      wr(8'h60, 32'h0);
   endtask

   task automatic t_basic;
      wr(8'h58, 32'h01);                // enable, field width 0
      request(5, 1'b1);
      cyc(1);
      check("R5 valid one cycle after request+status", 64'(m_valid), 64'd1);
      check("R3 payload width 0", 64'(m_data), 64'(exp_payload(16'h4321, 0, 5)));
      check("R4 address 32-bit", m_addr, 64'h0000_0000_FEE0_1000);
      check("R4 addr64 low", 64'(m_addr64), 64'd0);
      accept();
      check("R7 valid drops after handshake", 64'(m_valid), 64'd0);
   endtask

   task automatic t_fold;
      wr(8'h58, 32'h31);                // enable, field width 3
      wr(8'h60, 32'h0000_0001);
      request(5, 1'b1);
      cyc(1);
      check("R3 payload width 3", 64'(m_data), 64'(exp_payload(16'h4321, 3, 5)));
      check("R4 address 64-bit", m_addr, 64'h0000_0001_FEE0_1000);
      check("R4 addr64 high", 64'(m_addr64), 64'd1);
      accept();
      wr(8'h58, 32'h21);                // field width 2
      request(7, 1'b1);
      cyc(1);
      check("R3 payload width 2", 64'(m_data), 64'(exp_payload(16'h4321, 2, 7)));
      accept();
      wr(8'h60, 32'h0);
   endtask

   task automatic t_order;
      request(2, 1'b0);
      cyc(5);
      check("R5 no write before status pulse", 64'(m_valid), 64'd0);
      sblk_issued = 1'b1;
      cyc(1);
      sblk_issued = 1'b0;
      cyc(1);
      check("R5 write one cycle after status pulse", 64'(m_valid), 64'd1);
      check("R5 vector 2 payload", 64'(m_data), 64'(exp_payload(16'h4321, 2, 2)));
      accept();
   endtask

   task automatic t_enable;
      wr(8'h58, 32'h20);                // disabled, width 2
      request(1, 1'b1);
      cyc(5);
      check("R6 no write while disabled", 64'(m_valid), 64'd0);
      wr(8'h58, 32'h21);
      cyc(1);
      check("R6 pending released on enable", 64'(m_valid), 64'd1);
      check("R6 released vector 1", 64'(m_data), 64'(exp_payload(16'h4321, 2, 1)));
      accept();
   endtask

   task automatic t_hold;
      request(3, 1'b1);
      cyc(1);
      cyc(4);
      wr(8'h64, 32'h0000_BEEF);
      wr(8'h5C, 32'h0000_0040);
      check("R7 valid held", 64'(m_valid), 64'd1);
      check("R7 payload held", 64'(m_data), 64'(exp_payload(16'h4321, 2, 3)));
      check("R7 address held", m_addr, 64'h0000_0000_FEE0_1000);
      accept();
   endtask

   task automatic t_queue;
      // data now 0xBEEF, address 0x40, width 2
      request(2, 1'b1);
      cyc(1);
      request(3, 1'b1);
      request(1, 1'b1);
      request(1, 1'b1);
      cyc(2);
      check("R8 first still outstanding", 64'(m_data), 64'(exp_payload(16'hBEEF, 2, 2)));
      accept();
      cyc(1);
      check("R8 lowest index next", 64'(m_data), 64'(exp_payload(16'hBEEF, 2, 1)));
      check("R8 next valid", 64'(m_valid), 64'd1);
      accept();
      cyc(1);
      check("R8 vector 3 last", 64'(m_data), 64'(exp_payload(16'hBEEF, 2, 3)));
      accept();
      cyc(4);
      check("R9 duplicates merged, no extra write", 64'(m_valid), 64'd0);
   endtask

   task automatic t_reset_drop;
      wr(8'h58, 32'h00);
      request(4, 1'b1);
      do_reset();
      rd("R1 data cleared", 8'h64, 32'h0);
      wr(8'h58, 32'h01);
      cyc(5);
      check("R1 pending dropped by reset", 64'(m_valid), 64'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_regs();
      t_basic();
      t_fold();
      t_order();
      t_enable();
      t_hold();
      t_queue();
      t_reset_drop();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule